// File: doc/BRIEF.md
# I2C Register Slave with Auto-Advancing Pointer

This block is the serial front end of a ten-location byte register bank. It watches an oversampled I2C clock and data pair and decodes START, repeated START and STOP. It answers one fixed 7-bit device address and keeps an internal register pointer. A write transfer loads the pointer from its first byte and stores every later byte at the pointer. A read transfer returns bytes from the pointer. The pointer moves on by one location only after a data byte has been acknowledged.

The register bank sits outside the block. The block presents the pointer as `reg_addr`, gives a one-cycle write strobe with the data, and takes back the addressed byte combinationally on `rd_data`. It also reports that a read transfer is in progress and gives a one-cycle pulse on every STOP. SDA is an open-drain line: `sda_oe` high pulls the line low. A power-fail input aborts any transfer and resets the pointer. While it is asserted, the bus is ignored.

Top module: `i2c_regslave`

## Requirements
- R1: The slave acknowledges only an address byte whose upper seven bits equal 68h, so D0h selects write and D1h selects read. Any other address byte gets no acknowledge, and the slave ignores the bus until the next START.
- R2: In a write transfer, each data byte after the pointer byte produces exactly one single-cycle `wr_stb`. During that cycle `wr_data` carries the byte and `reg_addr` carries the pointer.
- R3: The slave holds SDA low through the ninth clock of the matched address byte, the pointer byte and every data byte it receives.
- R4: The pointer advances by one after each acknowledged data byte, in both directions. The address byte, the pointer byte and a read byte the master does not acknowledge leave it unchanged.
- R5: After an acknowledged read address, bytes are shifted out MSB first from `rd_data` at the current pointer. A read with no pointer write before it resumes from the stored pointer.
- R6: After the master withholds the acknowledge of a read byte, the slave releases SDA and drives nothing more until the next START.
- R7: The pointer wraps from 9 to 0. A pointer byte of 10 or more loads 0.
- R8: While `pwr_fail` is high, any transfer is aborted, SDA is released, the pointer is 0, no strobe is issued and bus activity has no effect.
- R9: Every STOP seen outside power fail produces a one-cycle `stop_pulse`.
- R10: `rd_active` rises when a read address is acknowledged and falls on STOP, START or power fail. `wr_stb` never fires while it is high.
- R11: Outside power fail, `sda_oe` changes only while SCL is low.
- R12: After reset, `sda_oe`, `wr_stb`, `rd_active` and `stop_pulse` are low and `reg_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_fail | input | 1 | Supply out of tolerance: abort, clear pointer, ignore bus |
| scl_in | input | 1 | Bus clock as seen on the pad |
| sda_in | input | 1 | Bus data as seen on the pad |
| sda_oe | output | 1 | High pulls SDA low (open drain) |
| reg_addr | output | 4 | Current register pointer |
| wr_stb | output | 1 | One-cycle write strobe to the bank |
| wr_data | output | 8 | Byte to write, valid with `wr_stb` |
| rd_data | input | 8 | Bank contents at `reg_addr` |
| rd_active | output | 1 | A read transfer is in progress |
| stop_pulse | output | 1 | One-cycle pulse on each STOP |

## Verification
On every cycle the assertions check the following: strobes and STOP pulses last one cycle, the pointer stays in range, a power-fail cycle releases SDA and zeroes the pointer, no write occurs during a read transfer, and SDA only changes under a low clock. Scenarios are needed for the rest. Those are the acknowledge pattern on each byte, data ordering and pointer advance across write, set-pointer read and current-address read, wraparound and out-of-range pointer loads, rejection of a foreign address, and pointer loss after power fail. The bench checks these against a behavioural bank model.

// File: rtl/i2c_regslave.sv
module i2c_regslave #(
  parameter logic [6:0] DEV_ADDR = 7'h68,
  parameter int NUM_REGS = 10,
  localparam int PW = $clog2(NUM_REGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_fail,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          sda_oe,
  output logic [PW-1:0] reg_addr,
  output logic          wr_stb,
  output logic [7:0]    wr_data,
  input  logic [7:0]    rd_data,
  output logic          rd_active,
  output logic          stop_pulse
);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_RXD, S_ACK, S_TX, S_RACK} st_t;
  typedef enum logic [1:0] {K_ADDR, K_PTR, K_DATA} kind_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_in};
      sda_sy <= {sda_sy[0], sda_in};
      scl_q  <= scl_sy[1];
      sda_q  <= sda_sy[1];
    end

  wire scl_s    = scl_sy[1];
  wire sda_s    = sda_sy[1];
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start_c  = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c   = scl_s & scl_q & ~sda_q & sda_s;

  st_t          st;
  kind_t        kind;
  logic [2:0]   cnt;
  logic [7:0]   sh;
  logic [PW-1:0] ptr;
  logic         oe, rdm, wstb, spulse, macked;
  logic [7:0]   wdat;

  wire [PW-1:0] ptr_inc = (ptr == PW'(NUM_REGS - 1)) ? '0 : ptr + 1'b1;
  wire          adr_hit = (sh[7:1] == DEV_ADDR);
  wire          ptr_ok  = (32'(sh) < NUM_REGS);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE;
      kind <= K_ADDR;
      cnt <= '0;
      sh <= '0;
      ptr <= '0;
      oe <= 1'b0;
      rdm <= 1'b0;
      wstb <= 1'b0;
      spulse <= 1'b0;
      macked <= 1'b0;
      wdat <= '0;
    end else begin
      wstb   <= 1'b0;
      spulse <= 1'b0;
      if (pwr_fail) begin
        st  <= S_IDLE;
        ptr <= '0;
        oe  <= 1'b0;
        rdm <= 1'b0;
      end else if (start_c) begin
        st   <= S_RX;
        kind <= K_ADDR;
        cnt  <= '0;
        oe   <= 1'b0;
        rdm  <= 1'b0;
      end else if (stop_c) begin
        st     <= S_IDLE;
        oe     <= 1'b0;
        rdm    <= 1'b0;
        spulse <= 1'b1;
      end else begin
        case (st)
          S_RX:
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 3'd1;
              if (cnt == 3'd7) st <= S_RXD;
            end
          S_RXD:
            if (scl_fall) begin
              case (kind)
                K_ADDR:
                  if (adr_hit) begin
                    oe  <= 1'b1;
                    rdm <= sh[0];
                    st  <= S_ACK;
                  end else begin
                    st <= S_IDLE;
                  end
                K_PTR: begin
                  ptr <= ptr_ok ? sh[PW-1:0] : '0;
                  oe  <= 1'b1;
                  st  <= S_ACK;
                end
                default: begin
                  wstb <= 1'b1;
                  wdat <= sh;
                  oe   <= 1'b1;
                  st   <= S_ACK;
                end
              endcase
            end
          S_ACK:
            if (scl_fall) begin
              cnt <= '0;
              if (kind == K_ADDR && rdm) begin
                st <= S_TX;
                sh <= rd_data;
                oe <= ~rd_data[7];
              end else begin
                oe <= 1'b0;
                st <= S_RX;
                if (kind == K_DATA) ptr <= ptr_inc;
                kind <= (kind == K_ADDR) ? K_PTR : K_DATA;
              end
            end
          S_TX:
            if (scl_fall) begin
              cnt <= cnt + 3'd1;
              if (cnt == 3'd7) begin
                oe <= 1'b0;
                st <= S_RACK;
              end else begin
                sh <= {sh[6:0], 1'b0};
                oe <= ~sh[6];
              end
            end
          S_RACK:
            if (scl_rise) begin
              macked <= ~sda_s;
              if (!sda_s) ptr <= ptr_inc;
            end else if (scl_fall) begin
              cnt <= '0;
              if (macked) begin
                st <= S_TX;
                sh <= rd_data;
                oe <= ~rd_data[7];
              end else begin
                st <= S_IDLE;
              end
            end
          default: ;
        endcase
      end
    end

  assign sda_oe     = oe;
  assign reg_addr   = ptr;
  assign wr_stb     = wstb;
  assign wr_data    = wdat;
  assign rd_active  = rdm;
  assign stop_pulse = spulse;

endmodule

module i2c_regslave_chk #(
  parameter int NUM_REGS = 10,
  localparam int PW = $clog2(NUM_REGS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pwr_fail,
  input logic          scl_in,
  input logic          sda_oe,
  input logic [PW-1:0] reg_addr,
  input logic          wr_stb,
  input logic          rd_active,
  input logic          stop_pulse
);

  a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  a_r7_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    32'(reg_addr) < NUM_REGS);

  a_r8_pf_release: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> (!sda_oe && reg_addr == '0));

  a_r8_pf_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> !$past(pwr_fail));

  a_r9_stop_single: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pulse |=> !stop_pulse);

  a_r10_no_write_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_active |-> !wr_stb);

  a_r11_sda_under_low_scl: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(pwr_fail) && (sda_oe != $past(sda_oe))) |-> !scl_in);

endmodule

bind i2c_regslave i2c_regslave_chk #(.NUM_REGS(NUM_REGS)) chk_i (.*);

// File: tb/i2c_regslave_tb.sv
module i2c_regslave_tb_top;
  localparam int NR = 10;
  localparam int Q  = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr_fail = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_oe, wr_stb, rd_active, stop_pulse;
  logic [3:0] reg_addr;
  logic [7:0] wr_data, rd_data;
  logic [7:0] bank [NR];
  wire        sda_line = sda_m & ~sda_oe;

  int nchk = 0, nfail = 0;
  int exp_bank [NR];
  int exp_ptr = 0;
  int stop_seen = 0, exp_stops = 0;
  int stb_seen = 0, exp_stb = 0;
  int r11_viol = 0;
  logic prev_oe = 1'b0;
  bit done = 0;

  always #10 clk = ~clk;

  i2c_regslave dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail),
    .scl_in(scl_m), .sda_in(sda_line), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .wr_stb(wr_stb), .wr_data(wr_data),
    .rd_data(rd_data), .rd_active(rd_active), .stop_pulse(stop_pulse)
  );

  always @(posedge clk)
    if (!rst_n) begin
      for (int i = 0; i < NR; i++) bank[i] <= 8'(i * 17 + 3);
    end else if (wr_stb) begin
      bank[reg_addr] <= wr_data;
    end

  assign rd_data = bank[reg_addr];

  always @(negedge clk)
    if (rst_n) begin
      if (stop_pulse) stop_seen++;
      if (wr_stb) stb_seen++;
      if (sda_oe != prev_oe && scl_m && !pwr_fail) r11_viol++;
      prev_oe = sda_oe;
    end

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start;
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic do_stop;
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b1; wq(Q);
    if (!pwr_fail) exp_stops++;
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; wq(Q);
    scl_m = 1'b1; wq(2 * Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    b = sda_line; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(a);
    ack = ~a;
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic give_ack);
    logic x;
    for (int i = 7; i >= 0; i--) begin
      bit_in(x);
      b[i] = x;
    end
    bit_out(~give_ack);
  endtask

  task automatic check_bank(input string req);
    for (int i = 0; i < NR; i++) check(req, bank[i], exp_bank[i]);
  endtask

  task automatic write_tx(input logic [7:0] p, input logic [7:0] d[$]);
    logic ack;
    do_start;
    send_byte(8'hD0, ack); check("R3 write address ack", ack, 1);
    send_byte(p, ack);     check("R3 pointer ack", ack, 1);
    exp_ptr = (p < NR) ? int'(p) : 0;
    foreach (d[i]) begin
      send_byte(d[i], ack); check("R3 data ack", ack, 1);
      exp_bank[exp_ptr] = d[i];
      exp_ptr = (exp_ptr + 1) % NR;
      exp_stb++;
    end
    do_stop;
    wq(4);
    check("R4 pointer after write", reg_addr, exp_ptr);
    check_bank("R2 bank contents");
    check("R2 strobe count", stb_seen, exp_stb);
  endtask

  task automatic read_tx(input bit set_ptr, input logic [7:0] p, input int n);
    logic ack, x;
    logic [7:0] b;
    do_start;
    if (set_ptr) begin
      send_byte(8'hD0, ack); check("R3 address ack", ack, 1);
      send_byte(p, ack);     check("R3 pointer ack", ack, 1);
      exp_ptr = (p < NR) ? int'(p) : 0;
      do_start;
    end
    send_byte(8'hD1, ack); check("R1 read address ack", ack, 1);
    check("R10 rd_active in read", rd_active, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(b, i < n - 1);
      check("R5 read data", b, exp_bank[exp_ptr]);
      if (i < n - 1) exp_ptr = (exp_ptr + 1) % NR;
    end
    bit_in(x);
    check("R6 SDA released after nack", x, 1);
    check("R6 sda_oe low after nack", sda_oe, 0);
    do_stop;
    wq(4);
    check("R10 rd_active after stop", rd_active, 0);
    check("R4 pointer after read", reg_addr, exp_ptr);
  endtask

  task automatic finish_up;
    check("R9 stop pulse count", stop_seen, exp_stops);
    check("R11 sda change with scl high", r11_viol, 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    logic ack;
    for (int i = 0; i < NR; i++) exp_bank[i] = (i * 17 + 3) & 8'hFF;
    wq(5);
    rst_n = 1'b1;
    wq(5);
    check("R12 reset sda_oe", sda_oe, 0);
    check("R12 reset reg_addr", reg_addr, 0);
    check("R12 reset rd_active", rd_active, 0);
    check("R12 reset wr_stb", wr_stb, 0);
    check("R12 reset stop_pulse", stop_pulse, 0);

    write_tx(8'h02, '{8'hA5, 8'h3C});
    write_tx(8'h08, '{8'h11, 8'h22, 8'h33});
    check("R7 wrap to 1", reg_addr, 1);
    write_tx(8'h0F, '{8'h44});
    check("R7 out-of-range pointer", bank[0], 8'h44);

    read_tx(1'b1, 8'h03, 3);
    check("R4 nack leaves pointer", reg_addr, 5);
    read_tx(1'b0, 8'h00, 2);
    read_tx(1'b1, 8'h09, 2);
    check("R7 read wrap", reg_addr, 0);

    do_start;
    send_byte(8'hA0, ack); check("R1 foreign address nack", ack, 0);
    send_byte(8'h55, ack); check("R1 ignored after foreign address", ack, 0);
    do_stop;
    wq(4);
    check_bank("R1 bank untouched");
    check("R1 pointer untouched", reg_addr, exp_ptr);

    do_start;
    send_byte(8'hD0, ack);
    send_byte(8'h06, ack);
    send_byte(8'h77, ack); check("R3 data ack before power fail", ack, 1);
    exp_bank[6] = 8'h77; exp_stb++;
    for (int i = 0; i < 4; i++) bit_out(1'b1);
    pwr_fail = 1'b1;
    wq(4);
    check("R8 pointer cleared", reg_addr, 0);
    check("R8 sda released", sda_oe, 0);
    do_start;
    send_byte(8'hD0, ack); check("R8 no ack in power fail", ack, 0);
    send_byte(8'h01, ack);
    send_byte(8'h99, ack);
    do_stop;
    wq(4);
    check_bank("R8 bank untouched in power fail");
    check("R8 no strobe in power fail", stb_seen, exp_stb);
    pwr_fail = 1'b0;
    exp_ptr = 0;
    wq(8);
    read_tx(1'b0, 8'h00, 1);

    done = 1;
    finish_up;
  end
endmodule